// File: doc/BRIEF.md
# Video Field Size Cropper

This stage sits between a pixel stream and the logic that stores fields in memory. Each input beat carries one pixel together with three markers: field start, line end and field end. A status bit on the field-end beat says the sender saw the field as damaged. The stage holds every field to a programmed width and height. Pixels past the width of a line are dropped. Lines past the height of the field are dropped. Lines and fields that come in short are passed through as they are, with no padding, so the memory behind the missing pixels keeps whatever it held before.

As the stage forwards a field, it counts lines from zero. It gives a one-cycle pulse when the line whose index matches a programmed threshold finishes. When the field ends, it reports what actually arrived: the longest line and the number of lines. It also raises a broken flag when the line count differs from the programmed height, or when the sender marked the field as damaged. There is no backpressure. Every output is registered and appears one clock after the beat that caused it.

Top module: `vfc_field_cropper`

## Requirements
- R1: After synchronous reset, out_valid, out_sof, out_eol, line_pulse and done_valid are all 0, and the stage counts as being outside any field.
- R2: cfg_width and cfg_height are captured on the beat that has in_sof=1. Changing them later in the field has no effect on that field's cropping or on its broken flag.
- R3: A beat at pixel index p (counted from 0 within a line) is forwarded only when p < captured width. Forwarded beats keep their order and data, and appear on the outputs one cycle after the input beat.
- R4: Beats on a line with index l (counted from 0 within a field) are forwarded only when l < captured height.
- R5: A line ends on a beat with in_eol=1 or in_eof=1. A short line is forwarded without padding. out_eol=1 marks the last forwarded beat of each line: either the line-ending beat, or the beat with p = width-1.
- R6: A field with fewer lines than the captured height is not padded. Its report gives the true line count.
- R7: done_broken=1 when the received line count differs from the captured height, or when in_broken=1 on the field-end beat. Otherwise it is 0.
- R8: line_pulse is high for one cycle, one cycle after the beat that ends the line whose index equals cfg_line_irq, but only when that index is below the captured height.
- R9: One cycle after the field-end beat, done_valid is high for one cycle. At the same time, done_width gives the longest received line length and done_height gives the received line count. Both saturate at 2^DIM_W-1.
- R10: Valid beats that arrive outside a field are ignored and produce no output, no pulse and no report. Such beats come before the first in_sof, or after an in_eof and before the next in_sof.
- R11: out_sof=1 exactly on the forwarded copy of the field-start beat. That beat is dropped when the captured width or height is 0.
- R12: An in_sof in the middle of a field restarts counting at pixel 0 of line 0 with newly captured dimensions. The cut-off field produces no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_data | input | PIX_W | Pixel payload |
| in_sof | input | 1 | Beat is the first pixel of a field |
| in_eol | input | 1 | Beat is the last pixel of a line |
| in_eof | input | 1 | Beat is the last pixel of a field |
| in_broken | input | 1 | Sender flags field as damaged (read on the field-end beat) |
| cfg_width | input | DIM_W | Programmed field width in pixels |
| cfg_height | input | DIM_W | Programmed field height in lines |
| cfg_line_irq | input | DIM_W | Line index that triggers line_pulse |
| out_valid | output | 1 | Forwarded beat present |
| out_data | output | PIX_W | Forwarded pixel |
| out_sof | output | 1 | Forwarded beat starts the field |
| out_eol | output | 1 | Forwarded beat is the last kept pixel of its line |
| line_pulse | output | 1 | Threshold line completed |
| done_valid | output | 1 | Field report strobe |
| done_width | output | DIM_W | Longest received line length |
| done_height | output | DIM_W | Received line count |
| done_broken | output | 1 | Field height mismatch or sender damage flag |

## Verification
Some properties are checked on every cycle:
- the captured dimensions stay fixed between field starts;
- no output beat appears without an input beat one cycle earlier;
- no output beat comes from a line at or beyond the captured height;
- out_sof and out_eol appear only on valid beats;
- pulses and reports follow a line-ending or field-ending beat.

The exact pixels that survive cropping, the report values, the broken decision and the restart after a mid-field start depend on whole fields of stimulus. Only the bench's scenarios can show these, by comparing against a reference model cycle by cycle.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  typedef enum logic {
    FLD_IDLE = 1'b0,
    FLD_OPEN = 1'b1
  } fld_state_e;

  localparam int VFC_DIM_W_DEFAULT = 17;
  localparam int VFC_PIX_W_DEFAULT = 24;
endpackage

// File: rtl/vfc_position.sv
module vfc_position
  import vfc_pkg::*;
#(
  parameter int DIM_W = VFC_DIM_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_valid,
  input  logic             beat_sof,
  input  logic             beat_line_end,
  input  logic             beat_eof,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height,
  output logic             accept,
  output logic [DIM_W-1:0] pix_idx,
  output logic [DIM_W-1:0] line_idx,
  output logic [DIM_W-1:0] width_eff,
  output logic [DIM_W-1:0] height_eff
);
  fld_state_e       state_q;
  logic [DIM_W-1:0] pix_q, line_q, width_q, height_q;
  logic [DIM_W-1:0] pix_inc, line_inc;

  // a field start always opens a field; other beats need an open field
  assign accept     = beat_valid && (beat_sof || (state_q == FLD_OPEN));
  assign pix_idx    = beat_sof ? '0 : pix_q;
  assign line_idx   = beat_sof ? '0 : line_q;
  assign width_eff  = beat_sof ? cfg_width  : width_q;
  assign height_eff = beat_sof ? cfg_height : height_q;

  // saturating increments keep counters from wrapping on endless lines
  assign pix_inc  = (&pix_idx)  ? pix_idx  : pix_idx  + 1'b1;
  assign line_inc = (&line_idx) ? line_idx : line_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= FLD_IDLE;
      pix_q    <= '0;
      line_q   <= '0;
      width_q  <= '0;
      height_q <= '0;
    end else if (accept) begin
      width_q  <= width_eff;
      height_q <= height_eff;
      pix_q    <= beat_line_end ? '0 : pix_inc;
      line_q   <= beat_line_end ? line_inc : line_idx;
      state_q  <= beat_eof ? FLD_IDLE : FLD_OPEN;
    end
  end

  // R2: captured dimensions only move on a field-start beat
  p_dims_held_r2: assert property (@(posedge clk) disable iff (rst)
    !(beat_valid && beat_sof) |=> ($stable(width_q) && $stable(height_q)));
endmodule

// File: rtl/vfc_crop_gate.sv
module vfc_crop_gate #(
  parameter int PIX_W = 24,
  parameter int DIM_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [PIX_W-1:0] beat_data,
  input  logic             beat_sof,
  input  logic             beat_line_end,
  input  logic [DIM_W-1:0] pix_idx,
  input  logic [DIM_W-1:0] line_idx,
  input  logic [DIM_W-1:0] width_eff,
  input  logic [DIM_W-1:0] height_eff,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  output logic             out_eol
);
  logic             keep;
  logic             last_kept;
  logic [DIM_W-1:0] width_last;

  assign width_last = width_eff - 1'b1;
  assign keep       = accept && (pix_idx < width_eff) && (line_idx < height_eff);
  assign last_kept  = beat_line_end || (pix_idx == width_last);

  // payload register carries no reset so it can map to plain fabric flops
  always_ff @(posedge clk) begin
    if (keep) out_data <= beat_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else begin
      out_valid <= keep;
      out_sof   <= keep && beat_sof;
      out_eol   <= keep && last_kept;
    end
  end

  // R11: start marker only rides on a real beat
  p_sof_on_beat_r11: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
  // R5: line-end marker only rides on a real beat
  p_eol_on_beat_r5: assert property (@(posedge clk) disable iff (rst)
    out_eol |-> out_valid);
endmodule

// File: rtl/vfc_field_stats.sv
module vfc_field_stats #(
  parameter int DIM_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             beat_sof,
  input  logic             beat_line_end,
  input  logic             beat_eof,
  input  logic             beat_broken,
  input  logic [DIM_W-1:0] pix_idx,
  input  logic [DIM_W-1:0] line_idx,
  input  logic [DIM_W-1:0] height_eff,
  input  logic [DIM_W-1:0] line_thresh,
  output logic             line_pulse,
  output logic             done_valid,
  output logic [DIM_W-1:0] done_width,
  output logic [DIM_W-1:0] done_height,
  output logic             done_broken
);
  logic [DIM_W-1:0] longest_q, longest_base, longest_nxt;
  logic [DIM_W-1:0] line_len, lines_rx;
  logic             hit_thresh;

  assign line_len     = (&pix_idx)  ? pix_idx  : pix_idx  + 1'b1;
  assign lines_rx     = (&line_idx) ? line_idx : line_idx + 1'b1;
  assign longest_base = beat_sof ? '0 : longest_q;
  assign longest_nxt  = (beat_line_end && (line_len > longest_base)) ? line_len : longest_base;
  assign hit_thresh   = (line_idx == line_thresh) && (line_idx < height_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      longest_q   <= '0;
      line_pulse  <= 1'b0;
      done_valid  <= 1'b0;
      done_width  <= '0;
      done_height <= '0;
      done_broken <= 1'b0;
    end else begin
      line_pulse <= accept && beat_line_end && hit_thresh;
      done_valid <= accept && beat_eof;
      if (accept) longest_q <= longest_nxt;
      if (accept && beat_eof) begin
        done_width  <= longest_nxt;
        done_height <= lines_rx;
        done_broken <= beat_broken || (lines_rx != height_eff);
      end
    end
  end

  // R9: a report only follows an accepted field-end beat
  p_report_after_eof_r9: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(accept && beat_eof));
  // R8: a pulse only follows an accepted line-ending beat
  p_pulse_after_line_r8: assert property (@(posedge clk) disable iff (rst)
    line_pulse |-> $past(accept && beat_line_end));
endmodule

// File: rtl/vfc_field_cropper.sv
module vfc_field_cropper
  import vfc_pkg::*;
#(
  parameter int PIX_W = VFC_PIX_W_DEFAULT,
  parameter int DIM_W = VFC_DIM_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic             in_eof,
  input  logic             in_broken,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [DIM_W-1:0] cfg_height,
  input  logic [DIM_W-1:0] cfg_line_irq,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  output logic             out_eol,
  output logic             line_pulse,
  output logic             done_valid,
  output logic [DIM_W-1:0] done_width,
  output logic [DIM_W-1:0] done_height,
  output logic             done_broken
);
  logic             accept;
  logic             line_end;
  logic [DIM_W-1:0] pix_idx, line_idx, width_eff, height_eff;

  // a field end closes the open line even without a line marker
  assign line_end = in_eol || in_eof;

  vfc_position #(.DIM_W(DIM_W)) u_pos (
    .clk          (clk),
    .rst          (rst),
    .beat_valid   (in_valid),
    .beat_sof     (in_sof),
    .beat_line_end(line_end),
    .beat_eof     (in_eof),
    .cfg_width    (cfg_width),
    .cfg_height   (cfg_height),
    .accept       (accept),
    .pix_idx      (pix_idx),
    .line_idx     (line_idx),
    .width_eff    (width_eff),
    .height_eff   (height_eff)
  );

  vfc_crop_gate #(.PIX_W(PIX_W), .DIM_W(DIM_W)) u_gate (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .beat_data    (in_data),
    .beat_sof     (in_sof),
    .beat_line_end(line_end),
    .pix_idx      (pix_idx),
    .line_idx     (line_idx),
    .width_eff    (width_eff),
    .height_eff   (height_eff),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_sof      (out_sof),
    .out_eol      (out_eol)
  );

  vfc_field_stats #(.DIM_W(DIM_W)) u_stats (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .beat_sof     (in_sof),
    .beat_line_end(line_end),
    .beat_eof     (in_eof),
    .beat_broken  (in_broken),
    .pix_idx      (pix_idx),
    .line_idx     (line_idx),
    .height_eff   (height_eff),
    .line_thresh  (cfg_line_irq),
    .line_pulse   (line_pulse),
    .done_valid   (done_valid),
    .done_width   (done_width),
    .done_height  (done_height),
    .done_broken  (done_broken)
  );

  // R10: every forwarded beat stems from an input beat one cycle earlier
  p_out_from_beat_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  // R4: nothing forwarded from a line at or past the captured height
  p_no_row_past_height_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(line_idx) < $past(height_eff)));
endmodule

// File: tb/vfc_field_cropper_tb_top.sv
module vfc_field_cropper_tb_top;
  localparam int PW = 16;
  localparam int DW = 17;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          in_valid, in_sof, in_eol, in_eof, in_broken;
  logic [PW-1:0] in_data;
  logic [DW-1:0] cfg_width, cfg_height, cfg_line_irq;
  logic          out_valid, out_sof, out_eol, line_pulse, done_valid, done_broken;
  logic [PW-1:0] out_data;
  logic [DW-1:0] done_width, done_height;

  vfc_field_cropper #(.PIX_W(PW), .DIM_W(DW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol), .in_eof(in_eof), .in_broken(in_broken),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_line_irq(cfg_line_irq),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol),
    .line_pulse(line_pulse), .done_valid(done_valid), .done_width(done_width),
    .done_height(done_height), .done_broken(done_broken)
  );

  typedef struct {
    logic          v;
    logic [PW-1:0] d;
    logic          s, e, lp, dv, db;
    logic [DW-1:0] dw, dh;
    string         tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done_flag = 1'b0;

  // configuration staged here, applied on the next driven beat
  logic [DW-1:0] nx_w, nx_h, nx_t;

  // reference model state
  bit            m_act = 1'b0;
  logic [DW-1:0] m_w = '0, m_h = '0, m_p = '0, m_l = '0, m_max = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic beat(input logic v, input logic [PW-1:0] d, input logic s, input logic e,
                      input logic f, input logic b, input string tag);
    exp_t x;
    logic [DW-1:0] p, l, len;
    logic lend;
    @(negedge clk);
    cfg_width = nx_w; cfg_height = nx_h; cfg_line_irq = nx_t;
    in_valid = v; in_data = d; in_sof = s; in_eol = e; in_eof = f; in_broken = b;
    x.v = 0; x.d = '0; x.s = 0; x.e = 0; x.lp = 0; x.dv = 0; x.db = 0;
    x.dw = '0; x.dh = '0; x.tag = tag;
    if (v && (s || m_act)) begin
      if (s) begin
        m_w = nx_w; m_h = nx_h; m_p = '0; m_l = '0; m_max = '0;
      end
      p = m_p; l = m_l; lend = e || f;
      if (p < m_w && l < m_h) begin
        x.v = 1; x.d = d; x.s = s;
        x.e = lend || (p == m_w - 1);
      end
      if (lend) begin
        len = p + 1;
        if (len > m_max) m_max = len;
        if (l == nx_t && l < m_h) x.lp = 1;
      end
      if (f) begin
        x.dv = 1; x.dw = m_max; x.dh = l + 1;
        x.db = b || ((l + 1) != m_h);
      end
      m_p = lend ? '0 : p + 1;
      m_l = lend ? l + 1 : l;
      m_act = !f;
    end
    q.push_back(x);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) beat(0, '0, 0, 0, 0, 0, tag);
  endtask

  // one line of n pixels; first beat may open the field, last may close it
  task automatic line(input int n, input logic [PW-1:0] base, input logic first_sof,
                      input logic last_eof, input logic with_eol, input logic brk, input string tag);
    for (int i = 0; i < n; i++) begin
      beat(1, base + PW'(i), (i == 0) && first_sof, (i == n-1) && with_eol,
           (i == n-1) && last_eof, (i == n-1) && brk, tag);
    end
  endtask

  // scoreboard monitor: one expected record per driven cycle
  always @(posedge clk) begin
    exp_t x;
    #2;
    if (!rst && q.size() > 0) begin
      x = q.pop_front();
      chk(x.tag, "out_valid", 32'(out_valid), 32'(x.v));
      if (x.v) begin
        chk(x.tag, "out_data", 32'(out_data), 32'(x.d));
        chk(x.tag, "out_sof",  32'(out_sof),  32'(x.s));
        chk(x.tag, "out_eol",  32'(out_eol),  32'(x.e));
      end
      chk(x.tag, "line_pulse", 32'(line_pulse), 32'(x.lp));
      chk(x.tag, "done_valid", 32'(done_valid), 32'(x.dv));
      if (x.dv) begin
        chk(x.tag, "done_width",  32'(done_width),  32'(x.dw));
        chk(x.tag, "done_height", 32'(done_height), 32'(x.dh));
        chk(x.tag, "done_broken", 32'(done_broken), 32'(x.db));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      done_flag = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; in_data = '0; in_sof = 0; in_eol = 0; in_eof = 0; in_broken = 0;
    nx_w = 4; nx_h = 3; nx_t = 1;
    cfg_width = nx_w; cfg_height = nx_h; cfg_line_irq = nx_t;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state of every strobe
    chk("R1", "out_valid",  32'(out_valid),  0);
    chk("R1", "out_sof",    32'(out_sof),    0);
    chk("R1", "line_pulse", 32'(line_pulse), 0);
    chk("R1", "done_valid", 32'(done_valid), 0);
    rst = 0;

    // R10: beats before any field start are ignored
    line(3, 16'h0100, 0, 0, 1, 0, "R10 pre-field");
    line(2, 16'h0110, 0, 1, 1, 0, "R10 stray end");

    // R3 R4 R8 R7 R9: oversize field 6x4 cropped to 4x3, pulse on line 1
    line(6, 16'h1000, 1, 0, 1, 0, "R3 crop width");
    line(6, 16'h1100, 0, 0, 1, 0, "R8 line pulse");
    line(6, 16'h1200, 0, 0, 1, 0, "R3 crop width");
    line(6, 16'h1300, 0, 1, 1, 0, "R4 drop rows R9 report R7 tall");
    idle(2, "R10 idle");

    // R10: beats after a field end are ignored
    line(3, 16'h1400, 0, 0, 1, 0, "R10 post-field");

    // R5 R6 R2: short lines and short field; config change mid-field is ignored
    nx_w = 4; nx_h = 3; nx_t = 0;
    line(2, 16'h2000, 1, 0, 1, 0, "R5 short line");
    nx_w = 1; nx_h = 2;
    line(2, 16'h2100, 0, 1, 1, 0, "R6 short field R2 held dims");
    idle(1, "R6 idle");

    // R7: exact-size field, clean then flagged by the sender
    nx_w = 3; nx_h = 2; nx_t = 5;
    line(3, 16'h3000, 1, 0, 1, 0, "R7 exact");
    line(3, 16'h3100, 0, 1, 1, 0, "R7 exact clean");
    line(3, 16'h3200, 1, 0, 1, 0, "R7 exact");
    line(3, 16'h3300, 0, 1, 1, 1, "R7 sender broken");

    // R5: field end without a line marker still closes the line
    nx_w = 8; nx_h = 2; nx_t = 1;
    line(3, 16'h4000, 1, 0, 1, 0, "R5 eof line");
    line(5, 16'h4100, 0, 1, 0, 0, "R5 eof closes line");

    // R12: restart in mid-field, cut-off field gives no report
    nx_w = 4; nx_h = 2; nx_t = 0;
    line(4, 16'h5000, 1, 0, 1, 0, "R12 first start");
    line(2, 16'h5100, 0, 0, 0, 0, "R12 partial");
    line(3, 16'h5200, 1, 0, 1, 0, "R12 restart");
    line(5, 16'h5300, 0, 1, 1, 0, "R12 restart end");

    // R11 R8: zero width drops everything including the start beat; threshold above height
    nx_w = 0; nx_h = 3; nx_t = 3;
    line(2, 16'h6000, 1, 0, 1, 0, "R11 zero width");
    line(2, 16'h6100, 0, 1, 1, 0, "R8 threshold beyond height");

    // R8: threshold at last kept line, single-beat lines
    nx_w = 2; nx_h = 2; nx_t = 1;
    line(1, 16'h7000, 1, 0, 1, 0, "R8 single beat");
    line(1, 16'h7100, 0, 1, 1, 0, "R8 last kept line");

    idle(4, "R1 drain");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule